// File: doc/BRIEF.md
# Split-Accumulator Multiply-Accumulate Unit

This block is a signed multiply-accumulate engine. A 42-bit accumulator collects the products of pairs of signed 16-bit operands. Software sees it as two words: a 10-bit upper part and a 32-bit lower part. Single-cycle strobes control it. They clear the accumulator, load either part from a 32-bit data bus, or add the product of the two operand ports.

The accumulator value can be read at any time through a half-select input. The upper part comes back sign-extended to 32 bits. Four flags are returned next to the read word. The zero and negative flags describe the whole 42-bit value rather than the selected word. The overflow and carry flags always read as clear. Operand fetch and address handling belong to the surrounding core. The engine sees only the values on its ports.

Top module: `mac_split_acc`

## Requirements
- R1: While rst_ni is low, the accumulator is held at zero. After release, both halves read 0 with flag_z_o high.
- R2: A cycle with clr_i high sets all 42 accumulator bits to zero. Afterwards, both halves read 0 with the zero flag set and the negative and overflow flags clear.
- R3: ld_lo_i stores all 32 bits of ld_data_i into the lower part. A later read of the lower part (rd_hi_i=0) returns those 32 bits unchanged.
- R4: ld_hi_i stores ld_data_i[9:0] into accumulator bits 41:32. A read of the upper part (rd_hi_i=1) returns them sign-extended from bit 9, so loading 0xA5A5A5A5 reads back as 0x000001A5 and loading 0x200 reads back as 0xFFFFFE00.
- R5: flag_v_o and flag_c_o read as 0 on every read, including reads after a load.
- R6: acc_i adds the full signed product op_a_i × op_b_i, sign-extended to 42 bits, to the accumulator. The sum wraps modulo 2^42 with no saturation.
- R7: flag_z_o is 1 exactly when all 42 accumulator bits are zero. flag_n_o equals accumulator bit 41. Both flags are the same whichever half is selected.
- R8: clr_i overrides every other strobe in the same cycle. A load overrides acc_i in the same cycle. ld_hi_i and ld_lo_i together load both parts, and each load alone leaves the other part unchanged.
- R9: After a clear, one accumulation of (-2)×2 reads as lower 0xFFFFFFFC and upper 0xFFFFFFFF with negative set. Eight accumulations of 0x7FFF×0x7FFF read as lower 0xFFF80008 and upper 0x00000001 with negative and zero clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Clear accumulator strobe |
| ld_hi_i | input | 1 | Load upper part strobe |
| ld_lo_i | input | 1 | Load lower part strobe |
| acc_i | input | 1 | Multiply-accumulate strobe |
| op_a_i | input | 16 | Signed multiplicand |
| op_b_i | input | 16 | Signed multiplier |
| ld_data_i | input | 32 | Load data bus |
| rd_hi_i | input | 1 | Read select: 1 upper part, 0 lower part |
| rd_data_o | output | 32 | Selected accumulator word |
| flag_z_o | output | 1 | Whole accumulator is zero |
| flag_n_o | output | 1 | Accumulator bit 41 |
| flag_v_o | output | 1 | Overflow flag, always 0 |
| flag_c_o | output | 1 | Carry flag, always 0 |

## Verification
Clear, the two loads and the accumulate can be asserted together in one cycle. The priority among them is where a design most easily goes wrong.

The random phase draws each strobe independently from $urandom with a fixed seed. This produces many collisions, for example clear with accumulate, a load with accumulate, and both loads at once. Directed cases force each pairing once.

After every command, a bench model that applies the stated priority predicts both halves and the flags. Any mismatch in the read word or in the flags is reported against the priority requirement or the relevant data requirement.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int unsigned OP_W   = 16;
  localparam int unsigned HI_W   = 10;
  localparam int unsigned LO_W   = 32;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ACC_W  = HI_W + LO_W;
  localparam int unsigned PROD_W = 2 * OP_W;
endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int unsigned OP_W = mac_pkg::OP_W,
  localparam int unsigned PROD_W = 2 * OP_W
) (
  input  logic [OP_W-1:0]   a_i,
  input  logic [OP_W-1:0]   b_i,
  output logic [PROD_W-1:0] prod_o
);
  always_comb prod_o = $signed(a_i) * $signed(b_i);
endmodule

// File: rtl/mac_acc_reg.sv
module mac_acc_reg #(
  parameter int unsigned HI_W   = mac_pkg::HI_W,
  parameter int unsigned LO_W   = mac_pkg::LO_W,
  parameter int unsigned PROD_W = mac_pkg::PROD_W,
  localparam int unsigned ACC_W = HI_W + LO_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              ld_hi_i,
  input  logic              ld_lo_i,
  input  logic              acc_i,
  input  logic [PROD_W-1:0] prod_i,
  input  logic [LO_W-1:0]   ld_data_i,
  output logic [ACC_W-1:0]  acc_o
);
  logic [ACC_W-1:0] acc_q, acc_d, prod_ext;

  // product sign-extended to accumulator width
  always_comb prod_ext = {{(ACC_W-PROD_W){prod_i[PROD_W-1]}}, prod_i};

  // priority: clear > load > accumulate
  always_comb begin
    acc_d = acc_q;
    if (clr_i) begin
      acc_d = '0;
    end else if (ld_hi_i || ld_lo_i) begin
      if (ld_hi_i) acc_d[ACC_W-1:LO_W] = ld_data_i[HI_W-1:0];
      if (ld_lo_i) acc_d[LO_W-1:0]     = ld_data_i;
    end else if (acc_i) begin
      acc_d = acc_q + prod_ext;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_q == '0));
  p_ld_lo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_lo_i && !clr_i) |=> (acc_q[LO_W-1:0] == $past(ld_data_i)));
  p_ld_hi_keeps_lo_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_hi_i && !ld_lo_i && !clr_i) |=> $stable(acc_q[LO_W-1:0]));
  p_ld_lo_keeps_hi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_lo_i && !ld_hi_i && !clr_i) |=> $stable(acc_q[ACC_W-1:LO_W]));
  p_accum_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !clr_i && !ld_hi_i && !ld_lo_i) |=>
      (acc_q == $past(acc_q) + {{(ACC_W-PROD_W){$past(prod_i[PROD_W-1])}}, $past(prod_i)}));
  p_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clr_i || ld_hi_i || ld_lo_i || acc_i) |=> $stable(acc_q));
endmodule

// File: rtl/mac_read_mux.sv
module mac_read_mux #(
  parameter int unsigned HI_W  = mac_pkg::HI_W,
  parameter int unsigned LO_W  = mac_pkg::LO_W,
  parameter int unsigned BUS_W = mac_pkg::BUS_W,
  localparam int unsigned ACC_W = HI_W + LO_W
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic             rd_hi_i,
  output logic [BUS_W-1:0] rd_data_o,
  output logic             flag_z_o,
  output logic             flag_n_o,
  output logic             flag_v_o,
  output logic             flag_c_o
);
  logic [BUS_W-1:0] hi_ext, lo_word;

  generate
    if (BUS_W > HI_W) begin : g_hi_sext
      assign hi_ext = {{(BUS_W-HI_W){acc_i[ACC_W-1]}}, acc_i[ACC_W-1:LO_W]};
    end else begin : g_hi_trunc
      assign hi_ext = acc_i[LO_W +: BUS_W];
    end
    if (BUS_W > LO_W) begin : g_lo_pad
      assign lo_word = {{(BUS_W-LO_W){1'b0}}, acc_i[LO_W-1:0]};
    end else begin : g_lo_fit
      assign lo_word = acc_i[BUS_W-1:0];
    end
  endgenerate

  always_comb begin
    rd_data_o = rd_hi_i ? hi_ext : lo_word;
    flag_z_o  = ~|acc_i;
    flag_n_o  = acc_i[ACC_W-1];
    flag_v_o  = 1'b0;  // wraps, never saturates
    flag_c_o  = 1'b0;
  end
endmodule

// File: rtl/mac_split_acc.sv
module mac_split_acc
  import mac_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             ld_hi_i,
  input  logic             ld_lo_i,
  input  logic             acc_i,
  input  logic [OP_W-1:0]  op_a_i,
  input  logic [OP_W-1:0]  op_b_i,
  input  logic [BUS_W-1:0] ld_data_i,
  input  logic             rd_hi_i,
  output logic [BUS_W-1:0] rd_data_o,
  output logic             flag_z_o,
  output logic             flag_n_o,
  output logic             flag_v_o,
  output logic             flag_c_o
);
  logic [PROD_W-1:0] prod;
  logic [ACC_W-1:0]  acc;

  mac_mult #(.OP_W(OP_W)) u_mult (
    .a_i   (op_a_i),
    .b_i   (op_b_i),
    .prod_o(prod)
  );

  mac_acc_reg #(.HI_W(HI_W), .LO_W(LO_W), .PROD_W(PROD_W)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_i),
    .ld_hi_i  (ld_hi_i),
    .ld_lo_i  (ld_lo_i),
    .acc_i    (acc_i),
    .prod_i   (prod),
    .ld_data_i(ld_data_i),
    .acc_o    (acc)
  );

  mac_read_mux #(.HI_W(HI_W), .LO_W(LO_W), .BUS_W(BUS_W)) u_rd (
    .acc_i    (acc),
    .rd_hi_i  (rd_hi_i),
    .rd_data_o(rd_data_o),
    .flag_z_o (flag_z_o),
    .flag_n_o (flag_n_o),
    .flag_v_o (flag_v_o),
    .flag_c_o (flag_c_o)
  );

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_v_o && !flag_c_o);
  p_hi_sext_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hi_i |-> (rd_data_o[BUS_W-1:HI_W] == {(BUS_W-HI_W){rd_data_o[HI_W-1]}}));
  p_zero_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_z_o |-> (!flag_n_o && rd_data_o == '0));
  p_neg_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hi_i && flag_n_o) |-> rd_data_o[BUS_W-1]);
  p_clr_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> flag_z_o);
endmodule

// File: tb/sim_mac_split_acc.sv
`timescale 1ns/1ps
module sim_mac_split_acc;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clr_i = 1'b0, ld_hi_i = 1'b0, ld_lo_i = 1'b0, acc_i = 1'b0;
  logic [15:0] op_a_i = '0, op_b_i = '0;
  logic [31:0] ld_data_i = '0;
  logic        rd_hi_i = 1'b0;
  logic [31:0] rd_data_o;
  logic        flag_z_o, flag_n_o, flag_v_o, flag_c_o;

  logic [41:0] model = '0;
  int errs = 0, checks = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  mac_split_acc u0 (.*);

  function automatic logic [31:0] exp_word(input logic [41:0] m, input logic hi);
    return hi ? {{22{m[41]}}, m[41:32]} : m[31:0];
  endfunction

  task automatic check_both(input string req);
    for (int h = 0; h < 2; h++) begin
      logic [31:0] ew;
      logic [3:0]  ef, af;
      rd_hi_i = h[0];
      #0.4;
      ew = exp_word(model, h[0]);
      ef = {model == 42'd0, model[41], 2'b00};
      af = {flag_z_o, flag_n_o, flag_v_o, flag_c_o};
      checks++;
      if (rd_data_o !== ew || af !== ef) begin
        errs++;
        $display("FAIL %s half=%0d data=%h flags(zncv)=%b expected data=%h flags=%b",
                 req, h, rd_data_o, af, ew, ef);
      end
    end
  endtask

  task automatic check_lit(input string req, input logic hi, input logic [31:0] ew,
                           input logic ez, input logic en);
    rd_hi_i = hi;
    #0.4;
    checks++;
    if (rd_data_o !== ew || flag_z_o !== ez || flag_n_o !== en) begin
      errs++;
      $display("FAIL %s half=%0d data=%h z=%b n=%b expected data=%h z=%b n=%b",
               req, hi, rd_data_o, flag_z_o, flag_n_o, ew, ez, en);
    end
  endtask

  // drive at negedge, commit at posedge, return at next negedge
  task automatic cmd(input logic c, input logic h, input logic l, input logic a,
                     input logic [15:0] x, input logic [15:0] y, input logic [31:0] d);
    logic [31:0] p;
    clr_i = c; ld_hi_i = h; ld_lo_i = l; acc_i = a;
    op_a_i = x; op_b_i = y; ld_data_i = d;
    @(posedge clk_i);
    p = $signed(x) * $signed(y);
    if (c) model = '0;
    else if (h || l) begin
      if (h) model[41:32] = d[9:0];
      if (l) model[31:0]  = d;
    end else if (a) model = model + {{10{p[31]}}, p};
    @(negedge clk_i);
    clr_i = 0; ld_hi_i = 0; ld_lo_i = 0; acc_i = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_lit("R1", 1'b0, 32'h0, 1'b1, 1'b0);
    check_both("R1");

    cmd(0, 0, 1, 0, 0, 0, 32'hA5A5A5A5);
    check_lit("R3", 1'b0, 32'hA5A5A5A5, 1'b0, 1'b0);
    check_both("R5");
    cmd(0, 1, 0, 0, 0, 0, 32'hA5A5A5A5);
    check_lit("R4", 1'b1, 32'h000001A5, 1'b0, 1'b0);
    check_lit("R8", 1'b0, 32'hA5A5A5A5, 1'b0, 1'b0);
    cmd(0, 1, 0, 0, 0, 0, 32'h00000200);
    check_lit("R4", 1'b1, 32'hFFFFFE00, 1'b0, 1'b1);
    check_both("R7");

    cmd(1, 0, 0, 0, 0, 0, 0);
    check_lit("R2", 1'b0, 32'h0, 1'b1, 1'b0);
    check_lit("R2", 1'b1, 32'h0, 1'b1, 1'b0);
    check_both("R2");

    cmd(0, 0, 0, 1, 16'hFFFE, 16'h0002, 0);
    check_lit("R9", 1'b0, 32'hFFFFFFFC, 1'b0, 1'b1);
    check_lit("R9", 1'b1, 32'hFFFFFFFF, 1'b0, 1'b1);

    cmd(1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) cmd(0, 0, 0, 1, 16'h7FFF, 16'h7FFF, 0);
    check_lit("R9", 1'b0, 32'hFFF80008, 1'b0, 1'b0);
    check_lit("R9", 1'b1, 32'h00000001, 1'b0, 1'b0);

    cmd(1, 0, 0, 0, 0, 0, 0);
    cmd(0, 0, 0, 1, 16'd2, 16'd2, 0);
    check_lit("R6", 1'b0, 32'd4, 1'b0, 1'b0);
    check_lit("R7", 1'b1, 32'd0, 1'b0, 1'b0);
    cmd(1, 0, 0, 0, 0, 0, 0);
    cmd(0, 0, 0, 1, 16'd0, 16'd0, 0);
    check_lit("R7", 1'b0, 32'd0, 1'b1, 1'b0);
    cmd(0, 0, 0, 1, 16'h8000, 16'h8000, 0);
    check_lit("R6", 1'b0, 32'h40000000, 1'b0, 1'b0);

    // wrap at 2^42: largest positive plus one
    cmd(0, 1, 1, 0, 0, 0, 32'hFFFFFFFF);
    cmd(0, 1, 0, 0, 0, 0, 32'h000001FF);
    cmd(0, 0, 0, 1, 16'd1, 16'd1, 0);
    check_lit("R6", 1'b1, 32'hFFFFFE00, 1'b0, 1'b1);
    check_lit("R6", 1'b0, 32'h0, 1'b0, 1'b1);

    // collisions
    cmd(1, 1, 1, 1, 16'd5, 16'd5, 32'h12345678);
    check_lit("R8", 1'b0, 32'h0, 1'b1, 1'b0);
    cmd(0, 0, 1, 1, 16'd5, 16'd5, 32'h0000_0010);
    check_lit("R8", 1'b0, 32'h10, 1'b0, 1'b0);
    cmd(0, 1, 1, 0, 0, 0, 32'h8765_4321);
    check_lit("R8", 1'b1, 32'hFFFFFF21, 1'b0, 1'b1);
    check_lit("R8", 1'b0, 32'h87654321, 1'b0, 1'b1);

    // constrained random with strobe collisions
    for (int i = 0; i < 600; i++) begin
      logic [15:0] a, b;
      a = 16'($urandom);
      b = 16'($urandom);
      if ($urandom % 4 == 0) a = ($urandom % 2) ? 16'h8000 : 16'h7FFF;
      if ($urandom % 4 == 0) b = ($urandom % 2) ? 16'h8000 : 16'hFFFF;
      cmd(($urandom % 12) == 0, ($urandom % 6) == 0, ($urandom % 6) == 0,
          ($urandom % 3) != 0, a, b, $urandom);
      check_both("R8");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule